// File: doc/BRIEF.md
# Byte-Queued SPI Master with Register Port

This block is a serial peripheral master driven through a small word-wide register port. Software queues bytes by writing a transmit data register; each byte enters a transmit queue and, unless master transfers are inhibited, the shift engine sends the queued bytes one after another on the serial pins. The byte clocked in on the receive line during each transfer is placed in a receive queue, which software empties by reading the receive data register. Both queues hold 256 bytes by default.

The serial side works in clock-idle-low, sample-on-rising-edge mode, most significant bit first. The serial clock runs at the system clock divided by an even parameter of at least 2. Chip-select lines are plain register bits, so software frames multi-byte transactions itself. Three single-cycle event pulses (byte finished, receive queue became full, received byte dropped) go to an interrupt unit outside the block.

The shift engine is a three-state machine: `SH_IDLE` (no transfer; leaves on a start request, loading the byte), `SH_LOW` (serial clock low for half a period; on expiry samples the input line and moves to `SH_HIGH`), and `SH_HIGH` (serial clock high for half a period; on expiry either shifts to the next bit and returns to `SH_LOW`, or, after the eighth bit, reports completion and returns to `SH_IDLE`). A synchronous soft reset forces `SH_IDLE` from any state.

Top module: `spim_top`

## Requirements
- R1: After reset the status register (offset 0x64) reads 0x5, the control register (0x60) reads 0, both occupancy registers read 0, the select register (0x70) reads 0xFFFFFFFF, all select lines are high and the serial clock is low.
- R2: A transfer is 8 serial clock periods of SCLK_DIV system cycles each, with the clock idle low; the output line changes only while the clock is low, bits go out most significant first, and the input line is sampled on each rising edge.
- R3: A byte written to the transmit data register (0x68) is queued; while the inhibit bit is 0 queued bytes are sent in order until the queue is empty, and each received byte is appended to the receive queue, read in order at 0x6C as the low 8 bits.
- R4: Control bit 8 inhibits transfers: while it is 1 no new transfer starts and queued bytes stay queued; writing it back to 0 resumes sending.
- R5: Writing control bit 5 empties the transmit queue and bit 6 empties the receive queue; neither bit is stored, so both read back as 0, while bit 8 reads back as written.
- R6: Writing exactly 0x0000000A to offset 0x40 returns every register, both queues and the shift engine to their reset state; writing any other value there has no effect.
- R7: Status bit 3 is transmit queue full, bit 2 transmit empty, bit 1 receive full, bit 0 receive empty; writes to the status register have no effect.
- R8: A byte received while the receive queue holds 256 entries is dropped, the queue contents are kept and `ev_overrun` pulses for one cycle.
- R9: Reading the receive data register while the receive queue is empty returns 0xDEADBEEF and changes no state.
- R10: Select line i is low exactly when bit i of the select register is 0; bits above NSEL read as 1.
- R11: The occupancy registers at 0x74 (transmit) and 0x78 (receive) return the entry count minus one, or 0 when empty.
- R12: Each queue holds 256 bytes; a transmit data write while the transmit queue is full is ignored.
- R13: `ev_byte_done` pulses once per finished byte, and `ev_rx_full` pulses once when a received byte makes the receive queue full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 7 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at 0x6C) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | NSEL | Active-low select lines |
| ev_byte_done | output | 1 | Pulse: one byte transfer finished |
| ev_rx_full | output | 1 | Pulse: receive queue became full |
| ev_overrun | output | 1 | Pulse: received byte dropped |

## Verification
The bench fills the transmit queue past 256 entries while transfers are inhibited, then lets it drain into the receive queue until that is full and sends one more byte; a design with an off-by-one depth, a wrapped counter or a missing drop would show the wrong status, a wrong occupancy or overwrite the oldest received byte. It sets the inhibit bit together with the transmit-queue reset and checks that the flushed bytes are never sent, and that the self-clearing bits read back as 0. It writes a wrong key to the reset register and an empty-queue read of the receive register, where a loose decode would reset the block or a careless pop would corrupt the pointers. The serial pins are checked by capturing the output line on every rising clock edge against an inverting slave model, which exposes a reversed bit order or sampling on the wrong edge.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] OFF_RESET = 7'h40;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 7'h60;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 7'h64;
    localparam logic [ADDR_W-1:0] OFF_TXD   = 7'h68;
    localparam logic [ADDR_W-1:0] OFF_RXD   = 7'h6C;
    localparam logic [ADDR_W-1:0] OFF_SEL   = 7'h70;
    localparam logic [ADDR_W-1:0] OFF_TXOCC = 7'h74;
    localparam logic [ADDR_W-1:0] OFF_RXOCC = 7'h78;

    localparam logic [31:0] RESET_KEY = 32'h0000_000A;
    localparam logic [31:0] EMPTY_RD  = 32'hDEAD_BEEF;

    localparam int CTRL_TXCLR = 5;
    localparam int CTRL_RXCLR = 6;
    localparam int CTRL_INH   = 8;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_LOW  = 2'd1,
        SH_HIGH = 2'd2
    } sh_state_t;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     push,
    input  logic [W-1:0]             din,
    input  logic                     pop,
    output logic [W-1:0]             dout,
    output logic                     full,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R12: occupancy never passes the capacity
    a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    sh_state_t     state_q, state_d;
    logic [CW-1:0] cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    tx_sh, rx_sh;
    logic          tick, last_bit;

    assign tick     = (cnt == CW'(HALF_CYC - 1));
    assign last_bit = (bit_idx == 3'd7);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE: if (start) state_d = SH_LOW;
            SH_LOW:  if (tick)  state_d = SH_HIGH;
            SH_HIGH: if (tick)  state_d = last_bit ? SH_IDLE : SH_LOW;
            default: state_d = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= SH_IDLE;
        else if (clr) state_q <= SH_IDLE;
        else          state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
        end else if (clr) begin
            cnt     <= '0;
            bit_idx <= '0;
        end else begin
            unique case (state_q)
                SH_IDLE: begin
                    cnt <= '0;
                    if (start) begin
                        tx_sh   <= tx_byte;
                        bit_idx <= '0;
                    end
                end
                SH_LOW: begin
                    if (tick) begin
                        cnt   <= '0;
                        rx_sh <= {rx_sh[6:0], miso};
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SH_HIGH: begin
                    if (tick) begin
                        cnt <= '0;
                        if (!last_bit) begin
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    always_comb begin
        sclk    = (state_q == SH_HIGH);
        mosi    = tx_sh[7];
        busy    = (state_q != SH_IDLE);
        done    = (state_q == SH_HIGH) && tick && last_bit;
        rx_byte = rx_sh;
    end

    // R2: output data holds still for the whole high half of the clock
    a_r2_mosi_still_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_HIGH && $past(state_q) == SH_HIGH) |-> $stable(mosi));

endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int SCLK_DIV = 4,
    parameter int DEPTH    = 256,
    parameter int NSEL     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NSEL-1:0]   spi_ss_n,
    output logic              ev_byte_done,
    output logic              ev_rx_full,
    output logic              ev_overrun
);
    localparam int HALF  = SCLK_DIV / 2;
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic            inhibit;
    logic [NSEL-1:0] sel_q;
    logic            soft_rst, wr_ctrl, wr_sel;
    logic            tx_clr, rx_clr;
    logic            tx_push, tx_full, tx_empty;
    logic            rx_push, rx_pop, rx_full, rx_empty;
    logic [7:0]      tx_head, rx_head;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic            eng_start, eng_busy, eng_done;
    logic [7:0]      eng_rx;

    assign soft_rst  = reg_wr && reg_addr == OFF_RESET && reg_wdata == RESET_KEY;
    assign wr_ctrl   = reg_wr && reg_addr == OFF_CTRL;
    assign wr_sel    = reg_wr && reg_addr == OFF_SEL;
    assign tx_clr    = soft_rst || (wr_ctrl && reg_wdata[CTRL_TXCLR]);
    assign rx_clr    = soft_rst || (wr_ctrl && reg_wdata[CTRL_RXCLR]);
    assign tx_push   = reg_wr && reg_addr == OFF_TXD && !tx_full;
    assign rx_pop    = reg_rd && reg_addr == OFF_RXD && !rx_empty;
    assign rx_push   = eng_done && !rx_full;
    assign eng_start = !eng_busy && !inhibit && !tx_empty && !tx_clr;

    spim_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .din(reg_wdata[7:0]), .pop(eng_start),
        .dout(tx_head), .full(tx_full), .empty(tx_empty), .count(tx_cnt)
    );

    spim_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rx_push), .din(eng_rx), .pop(rx_pop),
        .dout(rx_head), .full(rx_full), .empty(rx_empty), .count(rx_cnt)
    );

    spim_shift #(.HALF_CYC(HALF)) u_eng (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .start(eng_start), .tx_byte(tx_head), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .busy(eng_busy),
        .done(eng_done), .rx_byte(eng_rx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inhibit <= 1'b0;
            sel_q   <= '1;
        end else if (soft_rst) begin
            inhibit <= 1'b0;
            sel_q   <= '1;
        end else begin
            if (wr_ctrl) inhibit <= reg_wdata[CTRL_INH];
            if (wr_sel)  sel_q   <= reg_wdata[NSEL-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_byte_done <= 1'b0;
            ev_rx_full   <= 1'b0;
            ev_overrun   <= 1'b0;
        end else if (soft_rst) begin
            ev_byte_done <= 1'b0;
            ev_rx_full   <= 1'b0;
            ev_overrun   <= 1'b0;
        end else begin
            ev_byte_done <= eng_done;
            ev_overrun   <= eng_done && rx_full;
            ev_rx_full   <= rx_push && !rx_pop && !rx_clr
                            && rx_cnt == CNT_W'(DEPTH - 1);
        end
    end

    assign spi_ss_n = sel_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CTRL:  reg_rdata[CTRL_INH] = inhibit;
            OFF_STAT:  reg_rdata[3:0] = {tx_full, tx_empty, rx_full, rx_empty};
            OFF_RXD:   reg_rdata = rx_empty ? EMPTY_RD : {24'd0, rx_head};
            OFF_SEL:   reg_rdata = {{(32-NSEL){1'b1}}, sel_q};
            OFF_TXOCC: reg_rdata = (tx_cnt == '0) ? '0 : 32'(tx_cnt - 1'b1);
            OFF_RXOCC: reg_rdata = (rx_cnt == '0) ? '0 : 32'(rx_cnt - 1'b1);
            default:   reg_rdata = '0;
        endcase
    end

    // R4: with transfers inhibited an idle engine stays idle
    a_r4_inhibit_keeps_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !eng_busy) |=> !eng_busy);

    // R8: a drop is only reported when the receive queue was full
    a_r8_overrun_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        ev_overrun |-> $past(rx_cnt) == CNT_W'(DEPTH));

    // R6: after a keyed soft reset every select line is released
    a_r6_reset_releases_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> (&spi_ss_n));

    // R10: select lines follow register bits only through register writes
    a_r10_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_sel) && !$past(soft_rst) |-> $stable(spi_ss_n));

endmodule

// File: tb/spim_top_tb.sv
module spim_top_tb;
    localparam int DIV   = 4;
    localparam int BYTE_CYC = 8 * DIV + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [0:0]  spi_ss_n;
    logic        ev_byte_done, ev_rx_full, ev_overrun;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int n_done = 0, n_full = 0, n_ovr = 0, n_high = 0;
    logic [7:0] cap = '0;
    logic sclk_prev = 1'b0;

    always #5 clk = ~clk;

    assign spi_miso = ~spi_mosi;   // inverting slave model

    spim_top #(.SCLK_DIV(DIV), .DEPTH(256), .NSEL(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_ss_n(spi_ss_n), .ev_byte_done(ev_byte_done),
        .ev_rx_full(ev_rx_full), .ev_overrun(ev_overrun)
    );

    always @(negedge clk) begin
        n_done <= n_done + int'(ev_byte_done);
        n_full <= n_full + int'(ev_rx_full);
        n_ovr  <= n_ovr + int'(ev_overrun);
        n_high <= n_high + int'(spi_sclk);
        if (spi_sclk && !sclk_prev) cap <= {cap[6:0], spi_mosi};
        sclk_prev <= spi_sclk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(7'h64, v); chk("R1 status", v, 32'h5);
        rd(7'h60, v); chk("R1 control", v, 32'h0);
        rd(7'h74, v); chk("R1 tx occupancy", v, 32'h0);
        rd(7'h78, v); chk("R1 rx occupancy", v, 32'h0);
        rd(7'h70, v); chk("R1 select reg", v, 32'hFFFF_FFFF);
        chk("R1 select pin", {31'd0, spi_ss_n}, 32'h1);
        chk("R1 sclk idle", {31'd0, spi_sclk}, 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        int d0, h0;
        d0 = n_done; h0 = n_high;
        wr(7'h68, 32'hA5);
        repeat (BYTE_CYC + 10) @(negedge clk);
        chk("R2 mosi msb first", {24'd0, cap}, 32'hA5);
        chk("R2 sclk high cycles", n_high - h0, 8 * (DIV / 2));
        chk("R13 one done pulse", n_done - d0, 1);
        rd(7'h6C, v); chk("R3 received byte", v, 32'h5A);
        rd(7'h64, v); chk("R7 status after read", v, 32'h5);
    endtask

    task automatic t_burst();
        logic [31:0] v;
        wr(7'h68, 32'h01); wr(7'h68, 32'h80); wr(7'h68, 32'h3C);
        repeat (3 * BYTE_CYC + 20) @(negedge clk);
        rd(7'h78, v); chk("R11 rx occupancy of 3", v, 32'h2);
        rd(7'h6C, v); chk("R3 order 1", v, 32'hFE);
        rd(7'h6C, v); chk("R3 order 2", v, 32'h7F);
        rd(7'h6C, v); chk("R3 order 3", v, 32'hC3);
        rd(7'h78, v); chk("R11 rx occupancy empty", v, 32'h0);
    endtask

    task automatic t_inhibit();
        logic [31:0] v;
        int d0;
        d0 = n_done;
        wr(7'h60, 32'h100);
        wr(7'h68, 32'h11); wr(7'h68, 32'h22);
        repeat (100) @(negedge clk);
        chk("R4 nothing sent while inhibited", n_done - d0, 0);
        rd(7'h74, v); chk("R11 tx occupancy of 2", v, 32'h1);
        rd(7'h60, v); chk("R5 inhibit reads back", v, 32'h100);
        wr(7'h60, 32'h0);
        repeat (2 * BYTE_CYC + 20) @(negedge clk);
        chk("R4 drain resumes", n_done - d0, 2);
        rd(7'h64, v); chk("R7 tx empty rx data", v, 32'h4);
    endtask

    task automatic t_fifo_reset();
        logic [31:0] v;
        int d0;
        wr(7'h60, 32'h40);
        rd(7'h64, v); chk("R5 rx queue cleared", v, 32'h5);
        rd(7'h60, v); chk("R5 clear bit reads 0", v, 32'h0);
        wr(7'h60, 32'h100);
        wr(7'h68, 32'h31); wr(7'h68, 32'h32); wr(7'h68, 32'h33);
        wr(7'h60, 32'h120);
        rd(7'h74, v); chk("R5 tx queue cleared", v, 32'h0);
        rd(7'h64, v); chk("R5 status after tx clear", v, 32'h5);
        rd(7'h60, v); chk("R5 only inhibit kept", v, 32'h100);
        d0 = n_done;
        wr(7'h60, 32'h0);
        repeat (50) @(negedge clk);
        chk("R5 flushed bytes never sent", n_done - d0, 0);
    endtask

    task automatic t_status_write();
        logic [31:0] v;
        wr(7'h64, 32'hF);
        rd(7'h64, v); chk("R7 status write ignored", v, 32'h5);
    endtask

    task automatic t_empty_read();
        logic [31:0] v;
        rd(7'h6C, v); chk("R9 empty read value", v, 32'hDEAD_BEEF);
        rd(7'h78, v); chk("R9 occupancy unchanged", v, 32'h0);
        rd(7'h64, v); chk("R9 status unchanged", v, 32'h5);
    endtask

    task automatic t_select();
        logic [31:0] v;
        wr(7'h70, 32'h0);
        chk("R10 line low on 0", {31'd0, spi_ss_n}, 32'h0);
        rd(7'h70, v); chk("R10 upper bits read 1", v, 32'hFFFF_FFFE);
        wr(7'h70, 32'h1);
        chk("R10 line high on 1", {31'd0, spi_ss_n}, 32'h1);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        wr(7'h70, 32'h0);
        wr(7'h60, 32'h100);
        wr(7'h68, 32'hAA); wr(7'h68, 32'hBB);
        wr(7'h40, 32'h5);
        chk("R6 wrong key keeps select", {31'd0, spi_ss_n}, 32'h0);
        rd(7'h74, v); chk("R6 wrong key keeps tx queue", v, 32'h1);
        rd(7'h60, v); chk("R6 wrong key keeps control", v, 32'h100);
        wr(7'h40, 32'hA);
        chk("R6 key releases select", {31'd0, spi_ss_n}, 32'h1);
        rd(7'h64, v); chk("R6 key resets status", v, 32'h5);
        rd(7'h60, v); chk("R6 key resets control", v, 32'h0);
        rd(7'h74, v); chk("R6 key empties tx queue", v, 32'h0);
    endtask

    task automatic t_capacity();
        logic [31:0] v;
        int d0, f0, o0;
        wr(7'h60, 32'h100);
        for (int i = 0; i < 257; i++) wr(7'h68, 32'(i));
        rd(7'h64, v); chk("R12 tx full status", v, 32'h9);
        rd(7'h74, v); chk("R11 tx occupancy full", v, 32'hFF);
        d0 = n_done; f0 = n_full; o0 = n_ovr;
        wr(7'h60, 32'h0);
        repeat (256 * BYTE_CYC + 40) @(negedge clk);
        chk("R12 256 bytes sent", n_done - d0, 256);
        rd(7'h64, v); chk("R12 rx full status", v, 32'h6);
        rd(7'h78, v); chk("R11 rx occupancy full", v, 32'hFF);
        chk("R13 rx full pulse", n_full - f0, 1);
        chk("R8 no overrun yet", n_ovr - o0, 0);
        wr(7'h68, 32'h77);
        repeat (BYTE_CYC + 20) @(negedge clk);
        chk("R8 overrun pulse", n_ovr - o0, 1);
        rd(7'h78, v); chk("R8 rx occupancy kept", v, 32'hFF);
        rd(7'h6C, v); chk("R8 oldest byte kept", v, 32'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single();
        t_burst();
        t_inhibit();
        t_fifo_reset();
        t_status_write();
        t_empty_read();
        t_select();
        t_soft_reset();
        t_capacity();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule